// File: doc/BRIEF.md
# Debug Trace Port Clock Generator

This block derives the output clock of a debug message trace port from the system clock. A single write port loads a small configuration word. The word holds an enable bit, an idle-gating bit, a 3-bit division code and a port-width bit. The output runs at the system clock rate, or at one half, one quarter or one eighth of it. The divided rates have a 50% duty cycle and come from a counter. The full-rate setting passes the system clock through a gate built around a latch, so that no glitch reaches the output.

The block holds the output low while it is disabled. When idle gating is on, it can also stop the clock whenever the transmitter reports that it has nothing to send. Every start, stop or rate change is deferred to the end of a complete output period, so no output pulse is ever shortened. Alongside the clock, the block gives the transmitter a one-cycle tick for each output rising edge and a lane-enable mask for the data pins.

Top module: `trace_clk_gen`

## Requirements
- R1: After reset all configuration fields are 0: trace_clk and trace_tick are low, lane_en is 16'h0FFF and cfg_err is 0.
- R2: A cycle with cfg_we high loads the configuration from cfg_wdata: bit 0 is the enable, bit 1 is idle gating, bits 4:2 are the division code, bit 5 is full width and bit 6 clears the error flag. The new fields act from the next clock edge.
- R3: With enable at 0, trace_clk is held low once the current output period has completed, and no tick is produced.
- R4: With the port running, division codes 0, 1, 3 and 7 give a period of N = 1, 2, 4 and 8 system cycles. For N ≥ 2 the output is high for the first N/2 cycles of each period and low for the rest. For N = 1 the output follows the system clock's high phase.
- R5: A write carrying division code 2, 4, 5 or 6 leaves the previous legal divisor in effect and sets cfg_err. The other fields of that write still load. cfg_err stays set until a write with bit 6 high and a legal code clears it. If a write both clears the flag and carries an illegal code, the flag ends up set.
- R6: With gating at 1, the port runs only while tx_busy is high. With gating at 0, it runs whenever it is enabled, whatever tx_busy is.
- R7: A start, a stop or a divisor change takes effect only at the end of a full output period. A period that has begun always completes.
- R8: lane_en is 16'hFFFF when the full-width bit is 1 and 16'h0FFF when it is 0.
- R9: trace_tick is high for exactly the system cycles that begin an output period, which are the cycles in which trace_clk rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write word |
| tx_busy | input | 1 | Transmitter has a message in flight |
| trace_clk | output | 1 | Trace port output clock |
| trace_tick | output | 1 | One-cycle pulse per output rising edge |
| lane_en | output | 16 | Data lane enable mask |
| cfg_err | output | 1 | Sticky illegal division code flag |

## Verification
A wrong period counter or a wrong latched divisor shows up at trace_clk within one output period, at most eight system cycles. It appears as a high or low phase of the wrong length, or as a rising edge with no matching tick. A start or stop applied at the wrong moment shows up as a shortened pulse in the first period after the change. A bad configuration register shows up at once on lane_en or cfg_err, in the cycle after the write. The bench compares the output against a behavioural model in both clock phases of every cycle, so any of these faults is caught in the cycle where it first appears.

// File: rtl/trace_clk_gen.sv
module trace_clk_gen #(
  parameter int LANES  = 16,
  parameter int NARROW = 12,
  parameter int CW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic             tx_busy,
  output logic             trace_clk,
  output logic             trace_tick,
  output logic [LANES-1:0] lane_en,
  output logic             cfg_err
);
  localparam int B_EN   = 0;
  localparam int B_GATE = 1;
  localparam int B_DIV  = 2;
  localparam int B_FULL = 5;
  localparam int B_CLR  = 6;

  logic       cfg_en, cfg_gate, cfg_full;
  logic [1:0] cfg_sh;
  logic       err_q;

  logic [2:0] w_code;
  logic       w_ok;
  logic [1:0] w_sh;

  assign w_code = cfg_wdata[B_DIV +: 3];

  always_comb begin
    w_ok = 1'b1;
    w_sh = 2'd0;
    case (w_code)
      3'd0:    w_sh = 2'd0;
      3'd1:    w_sh = 2'd1;
      3'd3:    w_sh = 2'd2;
      3'd7:    w_sh = 2'd3;
      default: w_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_gate <= 1'b0;
      cfg_full <= 1'b0;
      cfg_sh   <= 2'd0;
      err_q    <= 1'b0;
    end else if (cfg_we) begin
      cfg_en   <= cfg_wdata[B_EN];
      cfg_gate <= cfg_wdata[B_GATE];
      cfg_full <= cfg_wdata[B_FULL];
      if (w_ok) cfg_sh <= w_sh;
      if (!w_ok) err_q <= 1'b1;
      else if (cfg_wdata[B_CLR]) err_q <= 1'b0;
    end
  end

  logic       act, out_q, tick_q;
  logic [1:0] sh;
  logic [2:0] ph;
  logic       n_act, n_out, n_tick;
  logic [1:0] n_sh;
  logic [2:0] n_ph;
  logic [2:0] last;
  logic [3:0] half, ph_inc;
  logic       run, bnd;

  assign run = cfg_en & (~cfg_gate | tx_busy);

  always_comb begin
    case (sh)
      2'd0:    last = 3'd0;
      2'd1:    last = 3'd1;
      2'd2:    last = 3'd3;
      default: last = 3'd7;
    endcase
  end

  assign half   = ({1'b0, last} + 4'd1) >> 1;
  assign ph_inc = {1'b0, ph} + 4'd1;
  assign bnd    = !act || (ph == last);

  always_comb begin
    if (bnd) begin
      n_act  = run;
      n_sh   = cfg_sh;
      n_ph   = 3'd0;
      n_out  = run && (cfg_sh != 2'd0);
      n_tick = run;
    end else begin
      n_act  = act;
      n_sh   = sh;
      n_ph   = ph_inc[2:0];
      n_out  = ph_inc < half;
      n_tick = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      sh     <= 2'd0;
      ph     <= 3'd0;
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      act    <= n_act;
      sh     <= n_sh;
      ph     <= n_ph;
      out_q  <= n_out;
      tick_q <= n_tick;
    end
  end

  logic gate_lat;
  always_latch begin
    if (!clk) gate_lat = n_act && (n_sh == 2'd0);
  end

  assign trace_clk  = (clk & gate_lat) | out_q;
  assign trace_tick = tick_q;
  assign lane_en    = {{(LANES-NARROW){cfg_full}}, {NARROW{1'b1}}};
  assign cfg_err    = err_q;
endmodule

// File: rtl/trace_clk_gen_chk.sv
module trace_clk_gen_chk #(
  parameter int LANES  = 16,
  parameter int NARROW = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             clr_bit,
  input logic             cfg_en,
  input logic             act,
  input logic             out_q,
  input logic [2:0]       ph,
  input logic [1:0]       sh,
  input logic             trace_tick,
  input logic [LANES-1:0] lane_en,
  input logic             cfg_err
);
  logic [2:0] end_ph;
  assign end_ph = (sh == 2'd0) ? 3'd0 : (sh == 2'd1) ? 3'd1 : (sh == 2'd2) ? 3'd3 : 3'd7;

  p_low_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_en[NARROW-1:0]) &&
    ($countones(lane_en[LANES-1:NARROW]) == 0 || $countones(lane_en[LANES-1:NARROW]) == LANES-NARROW));

  p_off_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !cfg_en) |=> (!act && !out_q));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !(cfg_we && clr_bit)) |=> cfg_err);

  p_period_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ph != end_ph) |=> (act && $stable(sh)));

  p_tick_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trace_tick |-> (act && ph == 3'd0));

  p_rise_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> trace_tick);
endmodule

bind trace_clk_gen trace_clk_gen_chk #(.LANES(LANES), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .clr_bit(cfg_wdata[6]),
  .cfg_en(cfg_en), .act(act), .out_q(out_q), .ph(ph), .sh(sh),
  .trace_tick(trace_tick), .lane_en(lane_en), .cfg_err(cfg_err)
);

// File: tb/trace_clk_gen_bench.sv
`timescale 1ns/1ps
module trace_clk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        tx_busy = 1'b0;
  logic        trace_clk, trace_tick, cfg_err;
  logic [15:0] lane_en;

  trace_clk_gen u_trace_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_busy(tx_busy), .trace_clk(trace_clk), .trace_tick(trace_tick),
    .lane_en(lane_en), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference
  bit m_en, m_gate, m_full, m_err, m_act;
  int m_cfg_n, m_n, m_cnt;

  function automatic int code_to_n(input int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    if (code == 3) return 4;
    if (code == 7) return 8;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_gate = 0; m_full = 0; m_err = 0; m_act = 0;
      m_cfg_n = 1; m_n = 1; m_cnt = 0;
    end else begin
      if (!m_act || m_cnt == m_n - 1) begin
        m_act = m_en && (!m_gate || tx_busy);
        m_n   = m_cfg_n;
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (cfg_we) begin
        int n;
        n = code_to_n(int'(cfg_wdata[4:2]));
        m_en   = cfg_wdata[0];
        m_gate = cfg_wdata[1];
        m_full = cfg_wdata[5];
        if (cfg_wdata[6]) m_err = 0;
        if (n == 0) m_err = 1;
        else m_cfg_n = n;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act_v, exp_v, $time);
    end
  endtask

  bit cmp_on = 1'b0;
  always @(posedge clk) begin
    if (cmp_on) begin
      bit e_hi, e_lo, e_tick;
      #2;
      e_hi   = m_act && (m_n == 1 || m_cnt < m_n / 2);
      e_tick = m_act && m_cnt == 0;
      check(trace_clk === e_hi, "R3/R4/R6/R7 trace_clk high phase", int'(trace_clk), int'(e_hi));
      check(trace_tick === e_tick, "R9 trace_tick", int'(trace_tick), int'(e_tick));
      check(lane_en === (m_full ? 16'hFFFF : 16'h0FFF), "R2/R8 lane_en", int'(lane_en),
            m_full ? 32'hFFFF : 32'h0FFF);
      check(cfg_err === m_err, "R5 cfg_err", int'(cfg_err), int'(m_err));
      #4;
      e_lo = m_act && m_n > 1 && m_cnt < m_n / 2;
      check(trace_clk === e_lo, "R4/R7 trace_clk low phase", int'(trace_clk), int'(e_lo));
    end
  end

  task automatic wr(input bit en, input bit gate, input int code, input bit full, input bit clr);
    @(negedge clk);
    cfg_wdata = {1'b0, clr, full, 3'(code), gate, en};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int lfsr = 32'h1ACE5;
  task automatic busy_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      tx_busy = (lfsr % 5) < 2;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    check(trace_clk === 1'b0, "R1 trace_clk after reset", int'(trace_clk), 0);
    check(trace_tick === 1'b0, "R1 trace_tick after reset", int'(trace_tick), 0);
    check(lane_en === 16'h0FFF, "R1 lane_en after reset", int'(lane_en), 32'h0FFF);
    check(cfg_err === 1'b0, "R1 cfg_err after reset", int'(cfg_err), 0);
    cmp_on = 1'b1;
    idle(5);
    // R4 each legal rate, free running
    wr(1, 0, 0, 0, 0); idle(20);
    wr(1, 0, 1, 1, 0); idle(30);
    wr(1, 0, 3, 0, 0); idle(40);
    wr(1, 0, 7, 1, 0); idle(5);
    // R7 change mid period, then R3 disable mid high phase
    wr(1, 0, 1, 1, 0); idle(20);
    wr(1, 0, 7, 0, 0); idle(9);
    wr(0, 0, 7, 0, 0); idle(20);
    // R5 illegal codes keep the divisor and set the flag
    wr(1, 0, 3, 0, 0); idle(12);
    wr(1, 0, 2, 0, 0); idle(12);
    wr(1, 0, 4, 1, 0); idle(12);
    wr(1, 0, 7, 1, 1); idle(20);
    wr(1, 0, 5, 0, 1); idle(12);
    wr(1, 0, 6, 0, 0); idle(12);
    wr(1, 0, 0, 0, 1); idle(12);
    // R6 idle gating at each rate
    for (int k = 0; k < 4; k++) begin
      wr(1, 1, (1 << k) - 1, k[0], 0);
      busy_noise(150);
    end
    // R6 gating off ignores tx_busy
    wr(1, 0, 3, 0, 0);
    busy_noise(60);
    tx_busy = 1'b0;
    wr(1, 1, 1, 0, 0); idle(20);
    wr(0, 1, 0, 0, 0); idle(20);
    cmp_on = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule